// File: doc/BRIEF.md
# Element-Strided Displacement Generator

This block produces the displacement used for one element of a vectorised load or store. The displacement field from the instruction is widened to a signed 32-bit immediate. Two field layouts are supported: a plain 16-bit field, and a word-aligned field whose low 14 bits are scaled by four. In unit-stride mode the block also folds in the element's position. The element and sub-element counters are flattened into one linear offset, scaled by the access size, and added to the immediate. A flag reports that the immediate was replaced.

The element indices come from the source side for a load and from the destination side for a store. The linear offset is `step * (sub_code + 1) + sub_index`. The access size is given as a power-of-two code, so the scaling is a left shift.

The result is registered. It appears one clock after the request, with a valid strobe that tracks the request strobe. Adding the base register and performing the memory access happen elsewhere.

Top module: `elem_disp_gen`

## Requirements
- R1: With `fmt_word` = 0, the immediate is `disp_field[15:0]` sign-extended from bit 15 to 32 bits.
- R2: With `fmt_word` = 1, the immediate is `{disp_field[13:0], 2'b00}` sign-extended from its bit 15 (field bit 13). Field bits 15:14 are ignored.
- R3: With `is_store` = 0 (load), the element offset is `src_idx * (sub_code + 1) + src_sub`, and the destination indices have no effect.
- R4: With `is_store` = 1 (store), the element offset is `dst_idx * (sub_code + 1) + dst_sub`, and the source indices have no effect.
- R5: With `unit_stride` = 1, `disp_out` equals the immediate plus (element offset << `len_code`), taken modulo 2^32, and `replaced` = 1. The codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes.
- R6: With `unit_stride` = 0, `disp_out` equals the immediate, `replaced` = 0, and the element indices, sub-vector code and length code have no effect.
- R7: A request sampled with `in_valid` = 1 at a rising edge shows its result on `disp_out`/`replaced` after that edge, with `out_valid` = 1. After an edge where `in_valid` = 0, `out_valid` = 0 and `disp_out`/`replaced` keep their previous values.
- R8: While `rst_n` is low at a rising edge, `out_valid`, `disp_out` and `replaced` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| disp_field | input | 16 | Raw displacement field from the instruction |
| fmt_word | input | 1 | 0: 16-bit field, 1: word-aligned 14-bit field |
| is_store | input | 1 | 0: load, 1: store |
| src_idx | input | 7 | Source element index |
| dst_idx | input | 7 | Destination element index |
| src_sub | input | 2 | Source sub-element index |
| dst_sub | input | 2 | Destination sub-element index |
| sub_code | input | 2 | Sub-vector length minus one |
| len_code | input | 2 | Access size as log2 of bytes |
| unit_stride | input | 1 | Enables element-offset folding |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| disp_out | output | 32 | Adjusted displacement |
| replaced | output | 1 | Displacement was replaced by the strided value |

## Verification
The assertions check the cycle-level behaviour on every cycle: the one-cycle valid pipeline, the holding of the result when no request arrives, the replace flag following the mode bit, and pass-through of the sign-extended 16-bit field. They also check that word-format immediates keep a zero low pair of bits and a consistent sign. The bench scenarios cover the full arithmetic. These include the choice between source and destination indices, the scaling for each access size, wrap-around of negative immediates, the largest indices, and the fact that the unused side's indices have no effect.

// File: rtl/edg_pkg.sv
// Shared encodings for the element-strided displacement generator.
// Assumes single-bit selects for format and operation direction.
package edg_pkg;
    typedef enum logic {
        FMT_D16  = 1'b0,
        FMT_WORD = 1'b1
    } disp_fmt_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_dir_e;
endpackage

// File: rtl/edg_base_ext.sv
// Widens the instruction displacement field into a signed immediate.
// Assumes FIELD_W >= 3 and OUT_W > FIELD_W; word format drops the top two
// field bits and appends two zero bits before sign extension.
module edg_base_ext
    import edg_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int OUT_W   = 32
) (
    input  logic [FIELD_W-1:0] field_i,
    input  disp_fmt_e          fmt_i,
    output logic [OUT_W-1:0]   imm_o
);
    localparam int EXT_W = OUT_W - FIELD_W;

    logic [FIELD_W-1:0] aligned;

    // Pick the field layout before extension.
    always_comb begin
        if (fmt_i == FMT_WORD) begin
            aligned = {field_i[FIELD_W-3:0], 2'b00};
        end else begin
            aligned = field_i;
        end
    end

    // Replicate the top bit of the aligned field.
    always_comb begin
        imm_o = {{EXT_W{aligned[FIELD_W-1]}}, aligned};
    end
endmodule

// File: rtl/edg_index_lin.sv
// Flattens an element index and a sub-element index into one linear offset:
// step * (sub_code + 1) + sub. The load side uses source indices and the
// store side uses destination indices. The multiply by a small factor is
// a set of shifted partial products, one per factor bit.
module edg_index_lin
    import edg_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2,
    localparam int LIN_W = STEP_W + SUB_W
) (
    input  mem_dir_e           dir_i,
    input  logic [STEP_W-1:0]  src_idx_i,
    input  logic [STEP_W-1:0]  dst_idx_i,
    input  logic [SUB_W-1:0]   src_sub_i,
    input  logic [SUB_W-1:0]   dst_sub_i,
    input  logic [SUB_W-1:0]   sub_code_i,
    output logic [LIN_W-1:0]   lin_o
);
    localparam int NPP = SUB_W + 1;

    logic [STEP_W-1:0] step;
    logic [SUB_W-1:0]  sub;
    logic [SUB_W:0]    factor;
    logic [LIN_W-1:0]  pp [NPP];

    // Select the index side from the operation direction.
    always_comb begin
        if (dir_i == OP_STORE) begin
            step = dst_idx_i;
            sub  = dst_sub_i;
        end else begin
            step = src_idx_i;
            sub  = src_sub_i;
        end
        factor = {1'b0, sub_code_i} + NPP'(1);
    end

    // One partial product for each bit of the factor.
    for (genvar g = 0; g < NPP; g++) begin : g_pp
        assign pp[g] = factor[g] ? (LIN_W'(step) << g) : '0;
    end

    // Sum the partial products and the sub-element index.
    always_comb begin
        lin_o = LIN_W'(sub);
        for (int k = 0; k < NPP; k++) begin
            lin_o = lin_o + pp[k];
        end
    end
endmodule

// File: rtl/edg_stride_acc.sv
// Scales the linear element offset by the access size, given as a
// power-of-two shift code, and adds it to the immediate in unit-stride
// mode. Otherwise it passes the immediate through. Assumes OUT_W is
// wide enough to hold the largest shifted offset.
module edg_stride_acc #(
    parameter int LIN_W = 9,
    parameter int LEN_W = 2,
    parameter int OUT_W = 32
) (
    input  logic [OUT_W-1:0] imm_i,
    input  logic [LIN_W-1:0] lin_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  logic             unit_stride_i,
    output logic [OUT_W-1:0] disp_o,
    output logic             repl_o
);
    localparam int NSH   = 1 << LEN_W;
    localparam int OFF_W = LIN_W + NSH - 1;

    logic [OFF_W-1:0] shv [NSH];
    logic [OFF_W-1:0] off_sel;

    // One shifted copy of the offset for each size code.
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        assign shv[g] = OFF_W'(lin_i) << g;
    end

    // Choose the scaled offset and form the result.
    always_comb begin
        off_sel = shv[len_code_i];
        if (unit_stride_i) begin
            disp_o = imm_i + {{(OUT_W-OFF_W){1'b0}}, off_sel};
            repl_o = 1'b1;
        end else begin
            disp_o = imm_i;
            repl_o = 1'b0;
        end
    end
endmodule

// File: rtl/elem_disp_gen.sv
// Top of the element-strided displacement generator. It combines the
// immediate widening, the index linearisation and the stride accumulation,
// then registers the result with one cycle of latency. The result holds
// while no request arrives. Synchronous active-low reset.
module elem_disp_gen
    import edg_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int STEP_W  = 7,
    parameter int SUB_W   = 2,
    parameter int LEN_W   = 2,
    parameter int OUT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] disp_field,
    input  logic               fmt_word,
    input  logic               is_store,
    input  logic [STEP_W-1:0]  src_idx,
    input  logic [STEP_W-1:0]  dst_idx,
    input  logic [SUB_W-1:0]   src_sub,
    input  logic [SUB_W-1:0]   dst_sub,
    input  logic [SUB_W-1:0]   sub_code,
    input  logic [LEN_W-1:0]   len_code,
    input  logic               unit_stride,
    output logic               out_valid,
    output logic [OUT_W-1:0]   disp_out,
    output logic               replaced
);
    localparam int LIN_W = STEP_W + SUB_W;

    logic [OUT_W-1:0] imm_w;
    logic [LIN_W-1:0] lin_w;
    logic [OUT_W-1:0] disp_w;
    logic             repl_w;

    edg_base_ext #(.FIELD_W(FIELD_W), .OUT_W(OUT_W)) u_base (
        .field_i (disp_field),
        .fmt_i   (disp_fmt_e'(fmt_word)),
        .imm_o   (imm_w)
    );

    edg_index_lin #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_lin (
        .dir_i      (mem_dir_e'(is_store)),
        .src_idx_i  (src_idx),
        .dst_idx_i  (dst_idx),
        .src_sub_i  (src_sub),
        .dst_sub_i  (dst_sub),
        .sub_code_i (sub_code),
        .lin_o      (lin_w)
    );

    edg_stride_acc #(.LIN_W(LIN_W), .LEN_W(LEN_W), .OUT_W(OUT_W)) u_acc (
        .imm_i         (imm_w),
        .lin_i         (lin_w),
        .len_code_i    (len_code),
        .unit_stride_i (unit_stride),
        .disp_o        (disp_w),
        .repl_o        (repl_w)
    );

    // Output register: valid tracks the request; data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            disp_out  <= '0;
            replaced  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                disp_out <= disp_w;
                replaced <= repl_w;
            end
        end
    end
endmodule

// File: rtl/elem_disp_gen_chk.sv
// Cycle-level properties of the displacement generator, bound to its top.
// Assumes the default 16-bit field and 32-bit output.
module elem_disp_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] disp_field,
    input logic        fmt_word,
    input logic        unit_stride,
    input logic        out_valid,
    input logic [31:0] disp_out,
    input logic        replaced
);
    logic [31:0] d16_ext;

    // Reference widening of the plain field, formed from the input port.
    always_comb d16_ext = {{16{disp_field[15]}}, disp_field};

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(disp_out) && $stable(replaced)));

    // R5, R6
    repl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (replaced == $past(unit_stride)));

    // R1
    d16_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !unit_stride && !fmt_word) |=> (disp_out == $past(d16_ext)));

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !unit_stride && fmt_word) |=>
        ((disp_out[1:0] == 2'b00) && (disp_out[31:15] == {17{disp_out[15]}})));
endmodule

bind elem_disp_gen elem_disp_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .disp_field  (disp_field),
    .fmt_word    (fmt_word),
    .unit_stride (unit_stride),
    .out_valid   (out_valid),
    .disp_out    (disp_out),
    .replaced    (replaced)
);

// File: tb/elem_disp_gen_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random requests.
module elem_disp_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] disp_field = '0;
    logic        fmt_word = 1'b0;
    logic        is_store = 1'b0;
    logic [6:0]  src_idx = '0;
    logic [6:0]  dst_idx = '0;
    logic [1:0]  src_sub = '0;
    logic [1:0]  dst_sub = '0;
    logic [1:0]  sub_code = '0;
    logic [1:0]  len_code = '0;
    logic        unit_stride = 1'b0;
    logic        out_valid;
    logic [31:0] disp_out;
    logic        replaced;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    elem_disp_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_field(disp_field),
        .fmt_word(fmt_word), .is_store(is_store), .src_idx(src_idx),
        .dst_idx(dst_idx), .src_sub(src_sub), .dst_sub(dst_sub),
        .sub_code(sub_code), .len_code(len_code), .unit_stride(unit_stride),
        .out_valid(out_valid), .disp_out(disp_out), .replaced(replaced)
    );

    function automatic logic [31:0] sext16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] exp_imm(input logic [15:0] f, input logic w);
        return w ? sext16({f[13:0], 2'b00}) : sext16(f);
    endfunction

    function automatic logic [31:0] exp_disp(input logic [15:0] f, input logic w,
        input logic st, input logic [6:0] si, input logic [6:0] di,
        input logic [1:0] ss, input logic [1:0] ds, input logic [1:0] sc,
        input logic [1:0] lc, input logic us);
        logic [31:0] off;
        off = st ? (32'(di) * (32'(sc) + 32'd1) + 32'(ds))
                 : (32'(si) * (32'(sc) + 32'd1) + 32'(ss));
        return us ? exp_imm(f, w) + (off << lc) : exp_imm(f, w);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge and check it at the next falling edge.
    task automatic req(input string tag, input logic [15:0] f, input logic w,
        input logic st, input logic [6:0] si, input logic [6:0] di,
        input logic [1:0] ss, input logic [1:0] ds, input logic [1:0] sc,
        input logic [1:0] lc, input logic us);
        disp_field = f; fmt_word = w; is_store = st; src_idx = si; dst_idx = di;
        src_sub = ss; dst_sub = ds; sub_code = sc; len_code = lc; unit_stride = us;
        in_valid = 1'b1;
        @(negedge clk);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " disp"}, disp_out, exp_disp(f, w, st, si, di, ss, ds, sc, lc, us));
        check({tag, " flag"}, {31'd0, replaced}, {31'd0, us});
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 disp_out", disp_out, 32'd0);
        check("R8 replaced", {31'd0, replaced}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 negative 16-bit field
        req("R1 neg", 16'h8000, 1'b0, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0);
        check("R1 value", disp_out, 32'hFFFF8000);
        // R2 word format, sign from field bit 13
        req("R2 neg", 16'h2000, 1'b1, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0);
        check("R2 value", disp_out, 32'hFFFF8000);
        // R2 top field bits ignored
        req("R2 top", 16'hC001, 1'b1, 1'b0, 7'd0, 7'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0);
        check("R2 ignore", disp_out, 32'h00000004);
        // R6 indices ignored outside unit stride
        req("R6 pass", 16'h0123, 1'b0, 1'b1, 7'd99, 7'd77, 2'd3, 2'd2, 2'd3, 2'd3, 1'b0);
        check("R6 value", disp_out, 32'h00000123);
        // R5 largest offset: 511 * 8 + 0x7FFF
        req("R5 max", 16'h7FFF, 1'b0, 1'b0, 7'd127, 7'd0, 2'd3, 2'd0, 2'd3, 2'd3, 1'b1);
        check("R5 max value", disp_out, 32'h00008FF7);
        // R5 negative base plus offset
        req("R5 wrap", 16'h8000, 1'b0, 1'b0, 7'd127, 7'd0, 2'd3, 2'd0, 2'd3, 2'd3, 1'b1);
        check("R5 wrap value", disp_out, 32'hFFFF8FF8);
        // R4 store uses dst: 2*2+0=4, times 4 bytes = 16
        req("R4 dst", 16'h0000, 1'b0, 1'b1, 7'd5, 7'd2, 2'd1, 2'd0, 2'd1, 2'd2, 1'b1);
        check("R4 value", disp_out, 32'h00000010);
        // R3 load uses src: 5*2+1=11, times 4 bytes = 44
        req("R3 src", 16'h0000, 1'b0, 1'b0, 7'd5, 7'd2, 2'd1, 2'd0, 2'd1, 2'd2, 1'b1);
        check("R3 value", disp_out, 32'h0000002C);

        // R7 hold: no request, inputs change, output keeps its value
        held = disp_out;
        in_valid = 1'b0;
        disp_field = 16'h5555; unit_stride = 1'b0;
        @(negedge clk);
        check("R7 valid low", {31'd0, out_valid}, 32'd0);
        check("R7 hold disp", disp_out, held);
        check("R7 hold flag", {31'd0, replaced}, 32'd1);

        // R3 R4 R5 R6 random requests
        for (int i = 0; i < 400; i++) begin
            logic st;
            st = 1'($urandom);
            req(st ? "R4 rand" : "R3 rand", 16'($urandom), 1'($urandom), st,
                7'($urandom), 7'($urandom), 2'($urandom), 2'($urandom),
                2'($urandom), 2'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check("R7 gap", {31'd0, out_valid}, 32'd0);
            end
        end

        // R8 reset mid-run clears the outputs
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid valid", {31'd0, out_valid}, 32'd0);
        check("R8 mid disp", disp_out, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule